// File: doc/BRIEF.md
# FIFO Threshold Interrupt Status Unit

This unit holds the transmit and receive byte queues of a serial-port controller, together with the interrupt logic that watches them. Both queues are 64 entries deep by default. The bus side pushes bytes into the transmit queue and pops bytes from the receive queue. The shift engine does the opposite and also reports the end of a transfer with a one-cycle pulse. Both occupancies are published in a single status word.

Three events can ask for service. The first is a receive queue that is three-quarters full. The second is a transmit queue that has drained to a quarter or less. The third is a completed transfer. Each event is latched in a status register, and software clears a bit by writing 1 to it. An enable register chooses which latched events drive the single interrupt line. A control write can empty either queue, or both queues at once.

The two queue flags follow the occupancy level. A flag that is cleared while its condition still holds stays set, so software cannot lose a pending condition by clearing it too early.

Top module: `fis_unit`

## Requirements
- R1: Each queue stores up to 64 bytes and returns them in push order. The head byte is visible on the pop data output while the queue is not empty. A push into a full queue and a pop from an empty queue are ignored, and a push while full is rejected even when a pop happens in the same cycle.
- R2: The occupancy word carries the receive count in bits 6:0 and the transmit count in bits 22:16. All other bits read 0. A count changes on the clock edge that takes the push or pop.
- R3: A control write with bit 8 set empties the transmit queue, and bit 9 empties the receive queue. Both may be set in one write. An emptying request overrides a push or pop to the same queue in that cycle.
- R4: Status bit 4 is set on the edge after any cycle in which the receive count is 48 or more.
- R5: Status bit 12 is set on the edge after any cycle in which the transmit count is 16 or less.
- R6: Status bit 16 is set on the edge after a transfer-done pulse. It stays set until it is cleared.
- R7: A status write clears every bit that is written as 1 and leaves the bits written as 0 alone, so writing all ones clears every flag. If the set condition of a bit holds in the same cycle (level still met, or a done pulse), that bit stays set.
- R8: In the enable register only bits 4, 12 and 16 are writable. All other bits read 0.
- R9: The interrupt output is high in the same cycle whenever any status bit and its enable bit are both 1, and low otherwise.
- R10: While reset is asserted, both counts, the status register, the enable register and the interrupt output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Bus writes a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to enqueue for transmit |
| tx_pop | input | 1 | Engine takes the head transmit byte |
| tx_pop_data | output | 8 | Head byte of the transmit queue |
| rx_push | input | 1 | Engine stores a received byte |
| rx_push_data | input | 8 | Received byte to enqueue |
| rx_pop | input | 1 | Bus reads the head receive byte |
| rx_pop_data | output | 8 | Head byte of the receive queue |
| xfer_done | input | 1 | One-cycle transfer completion pulse |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write data (bit 8 empties transmit, bit 9 empties receive) |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 32 | Enable register write data |
| ists_we | input | 1 | Status write-1-to-clear strobe |
| ists_wdata | input | 32 | Status clear mask |
| fifo_sts | output | 32 | Occupancy word |
| ien | output | 32 | Enable register value |
| ists | output | 32 | Status register value |
| irq | output | 1 | Interrupt request |

## Verification
Counts, the enable register and the status clears are due one edge after the stimulus. A queue flag is due one edge after the count it depends on, which makes it two edges after the push or pop that crossed the threshold. The interrupt output follows the status and enable registers in the same cycle. The bench applies each stimulus just after an edge and advances its reference model once per edge, using the values that held before that edge. It compares every output one nanosecond after the next edge. Directed checks inspect the lag cycle explicitly by showing the flag still low on the edge where the count reaches 48.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int REG_W        = 32;
  localparam int RX_FLAG_BIT  = 4;
  localparam int TX_FLAG_BIT  = 12;
  localparam int DONE_BIT     = 16;
  localparam int TX_FLUSH_BIT = 8;
  localparam int RX_FLUSH_BIT = 9;
  localparam int RX_CNT_LSB   = 0;
  localparam int TX_CNT_LSB   = 16;

  typedef struct packed {
    logic done;
    logic tx_low;
    logic rx_high;
  } ev_t;

  // receive queue is "nearly full" at three quarters of its depth
  function automatic int thresh_high(input int depth);
    return (depth * 3) / 4;
  endfunction

  // transmit queue is "nearly empty" at one quarter of its depth
  function automatic int thresh_low(input int depth);
    return depth / 4;
  endfunction

  function automatic ev_t bits_to_ev(input logic [REG_W-1:0] w);
    ev_t e;
    e.rx_high = w[RX_FLAG_BIT];
    e.tx_low  = w[TX_FLAG_BIT];
    e.done    = w[DONE_BIT];
    return e;
  endfunction

  function automatic logic [REG_W-1:0] ev_to_bits(input ev_t e);
    logic [REG_W-1:0] w;
    w = '0;
    w[RX_FLAG_BIT] = e.rx_high;
    w[TX_FLAG_BIT] = e.tx_low;
    w[DONE_BIT]    = e.done;
    return w;
  endfunction
endpackage

// File: rtl/fis_fifo.sv
module fis_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(count)); // R1
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (count == '0)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R3
endmodule

// File: rtl/fis_level_mon.sv
module fis_level_mon #(
  parameter int CW     = 7,
  parameter int THRESH = 48,
  parameter bit ABOVE  = 1'b1
) (
  input  logic [CW-1:0] cnt,
  output logic          hit
);
  generate
    if (ABOVE) begin : g_at_or_above
      assign hit = (cnt >= CW'(THRESH));
    end else begin : g_at_or_below
      assign hit = (cnt <= CW'(THRESH));
    end
  endgenerate
endmodule

// File: rtl/fis_irq_regs.sv
module fis_irq_regs
  import fis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_hit,
  input  logic             tx_hit,
  input  logic             done,
  input  logic             ien_we,
  input  logic [REG_W-1:0] ien_wdata,
  input  logic             ists_we,
  input  logic [REG_W-1:0] ists_wdata,
  output logic [REG_W-1:0] ien_q,
  output logic [REG_W-1:0] ists_q,
  output logic             irq
);
  ev_t en_r, st_r, set_v, clr_v;
  logic wr_unused;

  assign wr_unused = ^{ien_wdata, ists_wdata};
  assign set_v     = '{done: done, tx_low: tx_hit, rx_high: rx_hit};
  assign clr_v     = ists_we ? bits_to_ev(ists_wdata) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r <= '0;
      st_r <= '0;
    end else begin
      if (ien_we) en_r <= bits_to_ev(ien_wdata);
      st_r <= (st_r & ~clr_v) | set_v;
    end
  end

  assign ien_q  = ev_to_bits(en_r);
  assign ists_q = ev_to_bits(st_r);
  assign irq    = |(st_r & en_r);

  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |=> ists_q[RX_FLAG_BIT]); // R4
  AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hit |=> ists_q[TX_FLAG_BIT]); // R5
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ists_q[DONE_BIT]); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ists_q[DONE_BIT] && !ists_we) |=> ists_q[DONE_BIT]); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ists_we && ists_wdata[DONE_BIT] && !done) |=> !ists_q[DONE_BIT]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ists_q == '0) |-> !irq); // R9
endmodule

// File: rtl/fis_unit.sv
module fis_unit
  import fis_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_push_data,
  input  logic             tx_pop,
  output logic [DW-1:0]    tx_pop_data,
  input  logic             rx_push,
  input  logic [DW-1:0]    rx_push_data,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_pop_data,
  input  logic             xfer_done,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             ien_we,
  input  logic [REG_W-1:0] ien_wdata,
  input  logic             ists_we,
  input  logic [REG_W-1:0] ists_wdata,
  output logic [REG_W-1:0] fifo_sts,
  output logic [REG_W-1:0] ien,
  output logic [REG_W-1:0] ists,
  output logic             irq
);
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_flush, rx_flush;
  logic          rx_high_lvl, tx_low_lvl;
  logic          ctl_unused;

  assign ctl_unused = ^ctl_wdata;
  assign tx_flush   = ctl_we & ctl_wdata[TX_FLUSH_BIT];
  assign rx_flush   = ctl_we & ctl_wdata[RX_FLUSH_BIT];

  fis_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .wdata(tx_push_data),
    .pop(tx_pop), .rdata(tx_pop_data), .count(tx_cnt)
  );

  fis_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .wdata(rx_push_data),
    .pop(rx_pop), .rdata(rx_pop_data), .count(rx_cnt)
  );

  fis_level_mon #(.CW(CW), .THRESH(thresh_high(DEPTH)), .ABOVE(1'b1)) u_rx_mon (
    .cnt(rx_cnt), .hit(rx_high_lvl)
  );

  fis_level_mon #(.CW(CW), .THRESH(thresh_low(DEPTH)), .ABOVE(1'b0)) u_tx_mon (
    .cnt(tx_cnt), .hit(tx_low_lvl)
  );

  fis_irq_regs u_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_hit(rx_high_lvl), .tx_hit(tx_low_lvl), .done(xfer_done),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .ists_we(ists_we), .ists_wdata(ists_wdata),
    .ien_q(ien), .ists_q(ists), .irq(irq)
  );

  always_comb begin
    fifo_sts = '0;
    fifo_sts[RX_CNT_LSB +: CW] = rx_cnt;
    fifo_sts[TX_CNT_LSB +: CW] = tx_cnt;
  end

  AST_TX_FLUSH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (fifo_sts[TX_CNT_LSB +: CW] == '0)); // R3
  AST_RX_FLUSH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (fifo_sts[RX_CNT_LSB +: CW] == '0)); // R3
  AST_RX_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_push && !rx_pop && !rx_flush) |=> $stable(rx_cnt)); // R2
endmodule

// File: tb/fis_unit_tb.sv
`timescale 1ns/1ps
module fis_unit_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_push, tx_pop, rx_push, rx_pop, xfer_done;
  logic [7:0]  tx_push_data, rx_push_data, tx_pop_data, rx_pop_data;
  logic        ctl_we, ien_we, ists_we;
  logic [31:0] ctl_wdata, ien_wdata, ists_wdata;
  logic [31:0] fifo_sts, ien, ists;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  byte unsigned txq[$];
  byte unsigned rxq[$];
  logic [2:0] m_sts = '0; // {done, tx_low, rx_high}
  logic [2:0] m_en  = '0;

  always #4 clk = ~clk;

  fis_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
    .xfer_done(xfer_done), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .ists_we(ists_we), .ists_wdata(ists_wdata),
    .fifo_sts(fifo_sts), .ien(ien), .ists(ists), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ev_word(input logic [2:0] e);
    return (32'(e[0]) << 4) | (32'(e[1]) << 12) | (32'(e[2]) << 16);
  endfunction

  function automatic logic [31:0] cnt_word(input int r, input int t);
    return 32'(r) | (32'(t) << 16);
  endfunction

  function automatic logic [2:0] pick(input logic [31:0] w);
    return {w[16], w[12], w[4]};
  endfunction

  task automatic idle_inputs();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; xfer_done = 0;
    ctl_we = 0; ien_we = 0; ists_we = 0;
    tx_push_data = '0; rx_push_data = '0;
    ctl_wdata = '0; ien_wdata = '0; ists_wdata = '0;
  endtask

  // inputs are set by the caller; one edge is taken and every output compared
  task automatic step();
    logic [2:0] clr, lvl;
    bit tf, te, rf, re;
    if (tx_pop && txq.size() > 0) check("R1", "tx head byte", 32'(tx_pop_data), 32'(txq[0]));
    if (rx_pop && rxq.size() > 0) check("R1", "rx head byte", 32'(rx_pop_data), 32'(rxq[0]));
    lvl = {xfer_done, (txq.size() <= DEPTH / 4), (rxq.size() >= (DEPTH * 3) / 4)};
    clr = ists_we ? pick(ists_wdata) : 3'b000;
    tf = (txq.size() == DEPTH); te = (txq.size() == 0);
    rf = (rxq.size() == DEPTH); re = (rxq.size() == 0);
    @(posedge clk);
    #1;
    m_sts = (m_sts & ~clr) | lvl;
    if (ien_we) m_en = pick(ien_wdata);
    if (ctl_we && ctl_wdata[8]) txq.delete();
    else begin
      if (tx_pop && !te) void'(txq.pop_front());
      if (tx_push && !tf) txq.push_back(tx_push_data);
    end
    if (ctl_we && ctl_wdata[9]) rxq.delete();
    else begin
      if (rx_pop && !re) void'(rxq.pop_front());
      if (rx_push && !rf) rxq.push_back(rx_push_data);
    end
    idle_inputs();
    check("R2", "occupancy word", fifo_sts, cnt_word(rxq.size(), txq.size()));
    check("R4/R5/R6/R7", "status", ists, ev_word(m_sts));
    check("R8", "enable", ien, ev_word(m_en));
    check("R9", "irq", 32'(irq), 32'(|(m_sts & m_en)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset occupancy", fifo_sts, 32'h0);
    check("R10", "reset status", ists, 32'h0);
    check("R10", "reset enable", ien, 32'h0);
    check("R10", "reset irq", 32'(irq), 32'h0);
    rst_n = 1;

    // R8: only the three event bits stick
    ien_we = 1; ien_wdata = 32'hFFFF_FFFF; step();
    check("R8", "enable writable mask", ien, 32'h0001_1010);

    // R4: threshold crossing with one-cycle lag
    ists_we = 1; ists_wdata = 32'hFFFF_FFFF; step();
    for (int i = 0; i < 47; i++) begin rx_push = 1; rx_push_data = 8'(i * 7 + 3); step(); end
    step();
    check("R4", "flag low at 47", 32'(ists[4]), 32'h0);
    rx_push = 1; rx_push_data = 8'hA5; step();
    check("R4", "flag low on edge count reaches 48", 32'(ists[4]), 32'h0);
    step();
    check("R4", "flag set after 48", 32'(ists[4]), 32'h1);

    // R7: clearing while the level holds keeps the flag
    ists_we = 1; ists_wdata = 32'h0000_1010; step();
    check("R7", "rx flag kept while level holds", 32'(ists[4]), 32'h1);
    check("R7", "tx flag kept while level holds", 32'(ists[12]), 32'h1);

    // R1: overfill then drain in order, extra pops ignored
    for (int i = 0; i < 18; i++) begin rx_push = 1; rx_push_data = 8'($urandom); step(); end
    check("R1", "rx count capped at depth", 32'(fifo_sts[6:0]), 32'd64);
    rx_push = 1; rx_pop = 1; rx_push_data = 8'h5A; step();
    check("R1", "push while full rejected with pop", 32'(fifo_sts[6:0]), 32'd63);
    for (int i = 0; i < 65; i++) begin rx_pop = 1; step(); end
    check("R1", "rx empty after drain and extra pops", 32'(fifo_sts[6:0]), 32'd0);

    // R6/R7: transfer done latch
    xfer_done = 1; step();
    check("R6", "done latched", 32'(ists[16]), 32'h1);
    step();
    check("R6", "done held", 32'(ists[16]), 32'h1);
    ists_we = 1; ists_wdata = 32'h0001_0000; step();
    check("R7", "done cleared by write 1", 32'(ists[16]), 32'h0);
    xfer_done = 1; ists_we = 1; ists_wdata = 32'h0001_0000; step();
    check("R7", "done pulse wins over clear", 32'(ists[16]), 32'h1);

    // R5: tx flag clears above quarter, sets again at 16
    for (int i = 0; i < 17; i++) begin tx_push = 1; tx_push_data = 8'(200 - i); step(); end
    step();
    ists_we = 1; ists_wdata = 32'h0000_1000; step();
    check("R5", "tx flag clears at count 17", 32'(ists[12]), 32'h0);
    tx_pop = 1; step();
    step();
    check("R5", "tx flag set at count 16", 32'(ists[12]), 32'h1);

    // R3: both queues emptied by one write, overriding pushes
    for (int i = 0; i < 5; i++) begin rx_push = 1; rx_push_data = 8'(i); step(); end
    ctl_we = 1; ctl_wdata = 32'h0000_0300; tx_push = 1; rx_push = 1; tx_push_data = 8'h11; rx_push_data = 8'h22; step();
    check("R3", "both queues emptied", fifo_sts, 32'h0);

    // R9: interrupt gated by enable
    ien_we = 1; ien_wdata = 32'h0001_0000; ists_we = 1; ists_wdata = 32'hFFFF_FFFF; step();
    check("R9", "irq low with done clear", 32'(irq), 32'h0);
    xfer_done = 1; step();
    check("R9", "irq high with done enabled", 32'(irq), 32'h1);
    ien_we = 1; ien_wdata = 32'h0; step();
    check("R9", "irq low when disabled", 32'(irq), 32'h0);

    // random phases alternating fill and drain bias
    for (int ph = 0; ph < 8; ph++) begin
      for (int i = 0; i < 500; i++) begin
        int bias;
        bias = (ph % 2 == 0) ? 70 : 30;
        tx_push = ($urandom_range(99) < bias);
        tx_pop  = ($urandom_range(99) < 100 - bias);
        rx_push = ($urandom_range(99) < bias);
        rx_pop  = ($urandom_range(99) < 100 - bias);
        tx_push_data = 8'($urandom);
        rx_push_data = 8'($urandom);
        xfer_done = ($urandom_range(99) < 3);
        ien_we  = ($urandom_range(99) < 5);  ien_wdata  = $urandom;
        ists_we = ($urandom_range(99) < 10); ists_wdata = $urandom;
        ctl_we  = ($urandom_range(99) < 1);  ctl_wdata  = $urandom;
        step();
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule